// File: doc/BRIEF.md
# Write-Permission and Block-Protection Unit

This unit decides whether a serial memory device may commit a write. It keeps the write-enable latch, the write-in-progress flag and the stored protection settings. From these it builds the 8-bit status byte that a status read returns. A command engine sends it single-cycle strobes when a command completes. An external write-cycle timer sends it a busy level. The memory address, the hardware protect pin and these inputs together produce two registered permits. One permit says whether the current address may be written in the array. The other says whether the status register may be rewritten.

Protection comes from two independent sources. A two-bit range code locks the top quarter, the top half or the whole array. A stored enable bit combined with the protect pin guards only the status register. The enable latch gates every write. The stored settings are ordinary registers with a reset default. After any write cycle ends, the latch is cleared again.

Top module: `wrprot_unit`

## Requirements
- R1: After reset, status_o is 0x00 and both arr_ok_o and stat_ok_o are 0.
- R2: A pulse on set_en_i sets status bit 1 (the enable latch), and a pulse on clr_en_i clears it. When both arrive in the same cycle, the latch is cleared.
- R3: Status bit 0 shows busy_i one cycle late. In the cycle where that bit falls, the enable latch is also cleared.
- R4: The status byte holds the stored protect-enable bit at bit 7 and the range code at bits 3:2. Bits 6:4 always read 0.
- R5: A permitted status write loads only stat_data_i[7] into bit 7 and stat_data_i[3:2] into bits 3:2. Data bits 6:4 and 1:0 are ignored, and the enable latch is left set.
- R6: A status write is permitted only when the latch is 1, bit 0 is 0, and hardware protection is off. Hardware protection is on when bit 7 is 1 and wp_n_i is 0. A blocked status write leaves the status byte unchanged.
- R7: The range code blocks array addresses as follows: 00 blocks none, 01 blocks addresses whose two top bits are 11, 10 blocks addresses whose top bit is 1, and 11 blocks all addresses.
- R8: arr_ok_o can be 1 only while the latch is 1 and bit 0 is 0.
- R9: Hardware protection has no effect on arr_ok_o.
- R10: set_en_i and clr_en_i change the latch even while hardware protection is on or a write cycle is running.
- R11: A change on wp_n_i after a status write has been committed does not alter the stored bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| set_en_i | input | 1 | Write-enable command completed (strobe) |
| clr_en_i | input | 1 | Write-disable command completed (strobe) |
| stat_wr_i | input | 1 | Status-write command completed (strobe) |
| stat_data_i | input | 8 | Byte carried by the status write |
| busy_i | input | 1 | Internal write cycle running |
| wp_n_i | input | 1 | Hardware protect pin, low to protect |
| addr_i | input | ADDR_W | Array address under test |
| status_o | output | 8 | Assembled status byte |
| arr_ok_o | output | 1 | Array write permitted at addr_i |
| stat_ok_o | output | 1 | Status write permitted |

## Verification
A strobe or a change on busy_i shows in status_o after one rising edge. The two permits are registered from that updated state, so after a strobe they are due one edge later, on the second edge. After a change on only the address or the pin, a permit is due after one edge.

Each table vector is therefore applied at a falling edge, with its strobes held for one cycle. The vector is checked two falling edges later, when all three outputs have settled. The directed reset test checks outputs one edge after reset is released.

// File: rtl/wrprot_pkg.sv
package wrprot_pkg;
  localparam int STAT_W = 8;

  typedef enum logic [1:0] {
    PROT_NONE = 2'b00,
    PROT_QTR  = 2'b01,
    PROT_HALF = 2'b10,
    PROT_ALL  = 2'b11
  } prot_e;

  typedef struct packed {
    logic       wpen;
    logic [1:0] bp;
  } nvbits_t;
endpackage

// File: rtl/wel_ctl.sv
module wel_ctl (
  input  logic clk,
  input  logic rst,
  input  logic set_en_i,
  input  logic clr_en_i,
  input  logic busy_i,
  output logic wel_o,
  output logic wip_o
);
  logic cyc_end;
  assign cyc_end = wip_o & ~busy_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      wip_o <= 1'b0;
      wel_o <= 1'b0;
    end else begin
      wip_o <= busy_i;
      if (cyc_end | clr_en_i)
        wel_o <= 1'b0;
      else if (set_en_i)
        wel_o <= 1'b1;
    end
  end

  // R3
  wel_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wip_o) |-> !wel_o);

  // R2
  wel_set_chk: assert property (@(posedge clk) disable iff (rst)
    $past(set_en_i && !clr_en_i && !(wip_o && !busy_i)) |-> wel_o);
endmodule

// File: rtl/nv_store.sv
module nv_store
  import wrprot_pkg::*;
#(
  parameter logic       RST_WPEN = 1'b0,
  parameter logic [1:0] RST_BP   = 2'b00
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    commit_i,
  input  nvbits_t data_i,
  output nvbits_t nv_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      nv_o.wpen <= RST_WPEN;
      nv_o.bp   <= RST_BP;
    end else if (commit_i) begin
      nv_o <= data_i;
    end
  end

  // R6
  nv_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(commit_i) |-> $stable(nv_o));
endmodule

// File: rtl/range_guard.sv
module range_guard
  import wrprot_pkg::*;
(
  input  logic [1:0] top_i,
  input  prot_e      bp_i,
  output logic       hit_o
);
  always_comb begin
    unique case (bp_i)
      PROT_NONE: hit_o = 1'b0;
      PROT_QTR:  hit_o = &top_i;
      PROT_HALF: hit_o = top_i[1];
      default:   hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wrprot_unit.sv
module wrprot_unit
  import wrprot_pkg::*;
#(
  parameter int         ADDR_W   = 10,
  parameter logic       RST_WPEN = 1'b0,
  parameter logic [1:0] RST_BP   = 2'b00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en_i,
  input  logic              clr_en_i,
  input  logic              stat_wr_i,
  input  logic [STAT_W-1:0] stat_data_i,
  input  logic              busy_i,
  input  logic              wp_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [STAT_W-1:0] status_o,
  output logic              arr_ok_o,
  output logic              stat_ok_o
);
  localparam int TOP_LSB = ADDR_W - 2;

  logic    wel, wip, hw_lock, stat_perm, arr_perm, hit, commit;
  nvbits_t nv, nv_next;
  logic    unused_bits;

  assign unused_bits = ^{stat_data_i[6:4], stat_data_i[1:0], addr_i[TOP_LSB-1:0]};

  wel_ctl u_wel (
    .clk(clk), .rst(rst), .set_en_i(set_en_i), .clr_en_i(clr_en_i),
    .busy_i(busy_i), .wel_o(wel), .wip_o(wip)
  );

  assign hw_lock   = nv.wpen & ~wp_n_i;
  assign stat_perm = wel & ~wip & ~hw_lock;
  assign commit    = stat_wr_i & stat_perm;
  assign nv_next   = '{wpen: stat_data_i[7], bp: stat_data_i[3:2]};

  nv_store #(.RST_WPEN(RST_WPEN), .RST_BP(RST_BP)) u_nv (
    .clk(clk), .rst(rst), .commit_i(commit), .data_i(nv_next), .nv_o(nv)
  );

  range_guard u_rng (
    .top_i(addr_i[ADDR_W-1:TOP_LSB]), .bp_i(prot_e'(nv.bp)), .hit_o(hit)
  );

  assign arr_perm = wel & ~wip & ~hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      arr_ok_o  <= 1'b0;
      stat_ok_o <= 1'b0;
    end else begin
      arr_ok_o  <= arr_perm;
      stat_ok_o <= stat_perm;
    end
  end

  assign status_o = {nv.wpen, 3'b000, nv.bp, wel, wip};

  // R8
  arr_needs_wel_chk: assert property (@(posedge clk) disable iff (rst)
    arr_ok_o |-> $past(wel && !wip));

  // R7
  all_locked_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(nv.bp) == 2'b11) |-> !arr_ok_o);
endmodule

// File: tb/wrprot_unit_tb_top.sv
`timescale 1ns/1ps
module wrprot_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       set_en_i = 0, clr_en_i = 0, stat_wr_i = 0, busy_i = 0, wp_n_i = 1;
  logic [7:0] stat_data_i = 8'h00;
  logic [9:0] addr_i = 10'h000;
  logic [7:0] status_o;
  logic       arr_ok_o, stat_ok_o;
  int         n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  wrprot_unit #(.ADDR_W(10)) dut_i (
    .clk(clk), .rst(rst), .set_en_i(set_en_i), .clr_en_i(clr_en_i),
    .stat_wr_i(stat_wr_i), .stat_data_i(stat_data_i), .busy_i(busy_i),
    .wp_n_i(wp_n_i), .addr_i(addr_i), .status_o(status_o),
    .arr_ok_o(arr_ok_o), .stat_ok_o(stat_ok_o)
  );

  typedef struct packed {
    logic       set, clr, swr;
    logic [7:0] sdata;
    logic       busy, wpn;
    logic [9:0] addr;
    logic [7:0] est;
    logic       earr, esok;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{0,0,0,8'h00,0,1,10'h000,8'h00,0,0,4'd8},   // R8 latch clear blocks all
    '{1,0,0,8'h00,0,1,10'h000,8'h02,1,1,4'd2},   // R2 set latch
    '{0,0,1,8'hFF,0,1,10'h000,8'h8E,0,1,4'd5},   // R5 R4 status write
    '{0,0,0,8'h00,1,1,10'h000,8'h8F,0,0,4'd8},   // R8 busy blocks
    '{0,0,0,8'h00,0,1,10'h000,8'h8C,0,0,4'd3},   // R3 cycle end clears latch
    '{1,0,0,8'h00,0,0,10'h000,8'h8E,0,0,4'd10},  // R10 set under hw lock
    '{0,0,1,8'h00,0,0,10'h000,8'h8E,0,0,4'd6},   // R6 blocked status write
    '{1,1,0,8'h00,0,0,10'h000,8'h8C,0,0,4'd2},   // R2 clear wins
    '{1,0,0,8'h00,0,1,10'h000,8'h8E,0,1,4'd7},   // R7 all locked
    '{0,0,1,8'h74,0,1,10'h2FF,8'h06,1,1,4'd5},   // R5 only bits 7,3,2 stored
    '{0,0,0,8'h00,0,1,10'h300,8'h06,0,1,4'd7},   // R7 quarter edge
    '{0,0,1,8'h08,0,1,10'h1FF,8'h0A,1,1,4'd7},   // R7 half, below
    '{0,0,0,8'h00,0,1,10'h200,8'h0A,0,1,4'd7},   // R7 half edge
    '{0,0,1,8'h80,0,0,10'h3FF,8'h82,1,0,4'd9},   // R9 array open under hw lock
    '{0,0,1,8'h84,0,1,10'h3FF,8'h86,0,1,4'd7},   // R7 quarter top
    '{0,0,0,8'h00,0,0,10'h0FF,8'h86,1,0,4'd11},  // R11 pin drop after commit
    '{0,1,0,8'h00,1,0,10'h0FF,8'h85,0,0,4'd10},  // R10 clear during busy
    '{1,0,0,8'h00,1,0,10'h0FF,8'h87,0,0,4'd10},  // R10 set during busy
    '{0,0,0,8'h00,0,0,10'h0FF,8'h84,0,0,4'd3}    // R3 latch drops with busy flag
  };

  task automatic chk(input string what, input int req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %02h expected %02h", req, what, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("reset status", 1, status_o, 8'h00);
    chk("reset arr_ok", 1, {7'd0, arr_ok_o}, 8'h00);
    chk("reset stat_ok", 1, {7'd0, stat_ok_o}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      set_en_i = VEC[i].set; clr_en_i = VEC[i].clr; stat_wr_i = VEC[i].swr;
      stat_data_i = VEC[i].sdata; busy_i = VEC[i].busy;
      wp_n_i = VEC[i].wpn; addr_i = VEC[i].addr;
      @(negedge clk);
      set_en_i = 0; clr_en_i = 0; stat_wr_i = 0;
      @(negedge clk);
      chk($sformatf("vec %0d status", i), int'(VEC[i].req), status_o, VEC[i].est);
      chk($sformatf("vec %0d arr_ok", i), int'(VEC[i].req), {7'd0, arr_ok_o}, {7'd0, VEC[i].earr});
      chk($sformatf("vec %0d stat_ok", i), int'(VEC[i].req), {7'd0, stat_ok_o}, {7'd0, VEC[i].esok});
    end

    // R1 reset in mid-run returns stored bits to defaults
    set_en_i = 1; wp_n_i = 1; addr_i = 10'h000;
    @(negedge clk);
    set_en_i = 0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("mid reset status", 1, status_o, 8'h00);
    chk("mid reset arr_ok", 1, {7'd0, arr_ok_o}, 8'h00);
    chk("mid reset stat_ok", 1, {7'd0, stat_ok_o}, 8'h00);

    // R4 spare bits stay zero after a status write of all ones
    set_en_i = 1;
    @(negedge clk);
    set_en_i = 0; stat_wr_i = 1; stat_data_i = 8'hFF;
    @(negedge clk);
    stat_wr_i = 0;
    @(negedge clk);
    chk("spare bits", 4, status_o & 8'h70, 8'h00);
    chk("full write", 4, status_o, 8'h8E);

    finish_run();
  end
endmodule